// File: doc/BRIEF.md
# Two-Wire Bus Bit-Phase Master

This block turns single commands from a controller into the low-level waveforms of a two-wire serial bus with one master. Both bus lines are open-drain. The block does not drive a level onto a line. It raises an enable that pulls the line low, and a pull-up holds the line high when the enable is off. All timing comes from one delay unit, which lasts `tick_div` system clocks. Every step of every command is one or two of these units long, so the bus rate scales with this single input.

A controller sends one command at a time. There are five commands:
- bus recovery
- start condition
- stop condition
- byte write, which returns the acknowledge level the addressed device gives back
- byte read, which also sends an acknowledge bit chosen by the controller

The block raises `busy` while a command runs. When the command ends it pulses `done` and returns `rd_data` and `ack_level`. The block does no transaction sequencing, and it does not let a device hold the clock low.

State machine:
- `S_IDLE` waits for a command.
- Start runs `S_ST_SDA_HI` → `S_ST_SCL_HI` → `S_ST_SDA_LO`.
- Stop runs `S_SP_SCL_LO` → `S_SP_SDA_LO` → `S_SP_SCL_HI` → `S_SP_SDA_HI`.
- Write loops `S_WB_LOW` → `S_WB_SET` → `S_WB_HIGH` for each bit. It then runs the acknowledge slot `S_WA_LOW` → `S_WA_REL` → `S_WA_HIGH` → `S_WA_END`.
- Read loops `S_RB_LOW` → `S_RB_HIGH` → `S_RB_HOLD` for each bit. It then runs `S_RA_LOW` → `S_RA_DRIVE` → `S_RA_HIGH` → `S_RA_END`.
- Recovery loops `S_RC_LOW` → `S_RC_HIGH` nine times and then enters the stop chain.
- The last state of each chain returns to `S_IDLE` and pulses `done`.

Top module: `twp_master`

## Requirements
- R1: After reset, `scl_oe` = 0 and `sda_oe` = 0, so both lines are released. `busy` = 0 and `done` = 0.
- R2: One delay unit lasts `tick_div` clocks, and `tick_div` must be at least 1. The time from the accepting clock edge to the `done` cycle is `tick_div` × U clocks, where U is 3 for start, 4 for stop, 37 for write, 29 for read and 40 for recovery.
- R3: Start (op 3'd2) releases SDA, then releases SCL, then pulls SDA low while SCL is high. Each step is one unit. The command produces exactly one start condition and ends with SCL released and SDA pulled.
- R4: Stop (op 3'd3) pulls SCL, then pulls SDA, then releases SCL, then releases SDA while SCL is high. Each step is one unit. The command produces exactly one stop condition and ends with both lines released.
- R5: Write (op 3'd4) sends `cmd_wdata` most significant bit first. For each bit, SCL goes low, SDA takes the bit one unit later, and SCL is then high for two units. SDA changes only while SCL has been low for at least one clock.
- R6: After the eighth bit of a write, SDA is released for a ninth clock. SDA is sampled at the end of that clock's two-unit high phase. The sampled level is returned on `ack_level`: 0 means acknowledge, 1 means no acknowledge.
- R7: Read (op 3'd5) releases SDA and clocks eight bits. Each bit is sampled one unit after the SCL rising edge. The byte is returned on `rd_data`, first bit in the most significant position.
- R8: After the eight read bits, the level `cmd_ack` is placed on SDA for one ninth clock. A value of 0 pulls SDA low; a value of 1 leaves it released. SCL is high for two units during this clock and then returns low. `ack_level` returns the SDA level sampled at the end of that high phase.
- R9: Recovery (op 3'd1) keeps SDA released through nine SCL pulses. Each half of each pulse lasts two units. A full stop follows, so the bus sees ten SCL rising edges and both lines end released.
- R10: A command is accepted when `cmd_valid` is high and `busy` is low. `busy` is high from the next clock until the `done` cycle. `done` is a one-cycle pulse and `busy` is low while it is high.
- R11: A command offered while `busy` is high is ignored, as is any op code outside 3'd1 to 3'd5. It causes no `done`, no change to `busy` and no line change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_div | input | DIVW | Clocks per delay unit, at least 1 |
| cmd_valid | input | 1 | Command offer |
| cmd_op | input | 3 | Command code: 1 recover, 2 start, 3 stop, 4 write, 5 read |
| cmd_wdata | input | DATA_W | Byte to write |
| cmd_ack | input | 1 | Acknowledge level to send after a read |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Byte received by the last read |
| ack_level | output | 1 | SDA level sampled in the ninth clock |

## Verification
The bench repeats every command at several unit lengths, including a unit of one clock, where off-by-one faults in the tick counter show most clearly. A wrong counter or a wrong step length shows up as an end time that differs from U × `tick_div`.

A behavioural device on the bus returns acknowledges and read bytes, with both all-zero and all-one patterns. A bit order reversed, a sample taken one unit too early, or an acknowledge slot moved would give a wrong byte or a wrong acknowledge level.

Start and stop conditions are counted at the lines, and recovery is checked for ten rising edges with SDA released through the first nine. Commands offered in the middle of a write and unknown op codes must leave no trace; a design that accepted them would show an extra `done` or an extra stop condition.

// File: rtl/twp_pkg.sv
`timescale 1ns/1ps
package twp_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RECOVER = 3'd1,
        OP_START   = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_READ    = 3'd5
    } twp_op_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_ST_SDA_HI, S_ST_SCL_HI, S_ST_SDA_LO,
        S_SP_SCL_LO, S_SP_SDA_LO, S_SP_SCL_HI, S_SP_SDA_HI,
        S_WB_LOW, S_WB_SET, S_WB_HIGH,
        S_WA_LOW, S_WA_REL, S_WA_HIGH, S_WA_END,
        S_RB_LOW, S_RB_HIGH, S_RB_HOLD,
        S_RA_LOW, S_RA_DRIVE, S_RA_HIGH, S_RA_END,
        S_RC_LOW, S_RC_HIGH
    } twp_state_e;

    function automatic logic op_known(input logic [2:0] op);
        return (op >= 3'd1) && (op <= 3'd5);
    endfunction

    // Steps that last two delay units instead of one
    function automatic logic step_is_long(input twp_state_e s);
        return (s == S_WB_HIGH) || (s == S_WA_HIGH) || (s == S_RA_HIGH) ||
               (s == S_RC_LOW)  || (s == S_RC_HIGH);
    endfunction

    function automatic twp_state_e entry_of(input logic [2:0] op);
        case (op)
            3'd1:    return S_RC_LOW;
            3'd2:    return S_ST_SDA_HI;
            3'd3:    return S_SP_SCL_LO;
            3'd4:    return S_WB_LOW;
            3'd5:    return S_RB_LOW;
            default: return S_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/twp_unit_timer.sv
`timescale 1ns/1ps
module twp_unit_timer #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    localparam logic [DIVW-1:0] ONE = DIVW'(1);

    logic [DIVW-1:0] cnt_q;
    logic            at_end;

    assign at_end = (cnt_q == div - ONE);
    assign tick   = run && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (run)
            cnt_q <= at_end ? '0 : cnt_q + ONE;
    end
endmodule

// File: rtl/twp_shifter.sv
`timescale 1ns/1ps
module twp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[W-2:0], shift_in};
    end
endmodule

// File: rtl/twp_master.sv
`timescale 1ns/1ps
module twp_master
    import twp_pkg::*;
#(
    parameter int DIVW           = 8,
    parameter int DATA_W         = 8,
    parameter int RECOVER_PULSES = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIVW-1:0]   tick_div,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_ack,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_level
);
    localparam int MAXCNT = (DATA_W > RECOVER_PULSES) ? DATA_W : RECOVER_PULSES;
    localparam int CNTW   = $clog2(MAXCNT + 1);
    localparam logic [CNTW-1:0] LAST_BIT   = CNTW'(DATA_W - 1);
    localparam logic [CNTW-1:0] LAST_PULSE = CNTW'(RECOVER_PULSES - 1);

    twp_state_e      state_q, state_d;
    logic            unit_q;
    logic [CNTW-1:0] cnt_q;
    logic            ack_req_q;
    logic            done_q, finish;
    logic            scl_q, sda_q, ack_q;
    logic            accept, tick, step_end, cnt_step;
    logic [DATA_W-1:0] sh_q;

    assign busy     = (state_q != S_IDLE);
    assign accept   = cmd_valid && !busy && op_known(cmd_op);
    assign step_end = tick && (!step_is_long(state_q) || unit_q);
    assign cnt_step = step_end && ((state_q == S_WB_HIGH) || (state_q == S_RB_HOLD) ||
                                   (state_q == S_RC_HIGH));

    twp_unit_timer #(.DIVW(DIVW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy),
        .div(tick_div), .tick(tick)
    );

    twp_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cmd_wdata),
        .shift(step_end && ((state_q == S_WB_HIGH) || (state_q == S_RB_HIGH))),
        .shift_in((state_q == S_RB_HIGH) ? sda_in : 1'b0),
        .q(sh_q)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        if (state_q == S_IDLE) begin
            if (accept) state_d = entry_of(cmd_op);
        end else if (step_end) begin
            unique case (state_q)
                S_ST_SDA_HI: state_d = S_ST_SCL_HI;
                S_ST_SCL_HI: state_d = S_ST_SDA_LO;
                S_SP_SCL_LO: state_d = S_SP_SDA_LO;
                S_SP_SDA_LO: state_d = S_SP_SCL_HI;
                S_SP_SCL_HI: state_d = S_SP_SDA_HI;
                S_WB_LOW:    state_d = S_WB_SET;
                S_WB_SET:    state_d = S_WB_HIGH;
                S_WB_HIGH:   state_d = (cnt_q == LAST_BIT) ? S_WA_LOW : S_WB_LOW;
                S_WA_LOW:    state_d = S_WA_REL;
                S_WA_REL:    state_d = S_WA_HIGH;
                S_WA_HIGH:   state_d = S_WA_END;
                S_RB_LOW:    state_d = S_RB_HIGH;
                S_RB_HIGH:   state_d = S_RB_HOLD;
                S_RB_HOLD:   state_d = (cnt_q == LAST_BIT) ? S_RA_LOW : S_RB_LOW;
                S_RA_LOW:    state_d = S_RA_DRIVE;
                S_RA_DRIVE:  state_d = S_RA_HIGH;
                S_RA_HIGH:   state_d = S_RA_END;
                S_RC_LOW:    state_d = S_RC_HIGH;
                S_RC_HIGH:   state_d = (cnt_q == LAST_PULSE) ? S_SP_SCL_LO : S_RC_LOW;
                S_ST_SDA_LO, S_SP_SDA_HI, S_WA_END, S_RA_END: begin
                    state_d = S_IDLE;
                    finish  = 1'b1;
                end
                default:     state_d = S_IDLE;
            endcase
        end
    end

    // State register and step bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            unit_q    <= 1'b0;
            cnt_q     <= '0;
            ack_req_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (accept) begin
                unit_q    <= 1'b0;
                cnt_q     <= '0;
                ack_req_q <= cmd_ack;
            end else begin
                if (step_end)  unit_q <= 1'b0;
                else if (tick) unit_q <= 1'b1;
                if (cnt_step)  cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // Line actions taken on entry to each state, plus acknowledge sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b0;
            sda_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                unique case (state_d)
                    S_ST_SDA_HI, S_WA_REL, S_SP_SDA_HI: sda_q <= 1'b0;
                    S_ST_SDA_LO, S_SP_SDA_LO:           sda_q <= 1'b1;
                    S_ST_SCL_HI, S_SP_SCL_HI, S_WB_HIGH, S_WA_HIGH,
                    S_RB_HIGH, S_RA_HIGH, S_RC_HIGH:    scl_q <= 1'b0;
                    S_SP_SCL_LO, S_WB_LOW, S_WA_LOW, S_WA_END,
                    S_RA_LOW, S_RA_END:                 scl_q <= 1'b1;
                    S_RB_LOW, S_RC_LOW: begin
                        scl_q <= 1'b1;
                        sda_q <= 1'b0;
                    end
                    S_WB_SET:   sda_q <= !sh_q[DATA_W-1];
                    S_RA_DRIVE: sda_q <= !ack_req_q;
                    default: ;
                endcase
            end
            if (step_end && ((state_q == S_WA_HIGH) || (state_q == S_RA_HIGH)))
                ack_q <= sda_in;
        end
    end

    assign scl_oe    = scl_q;
    assign sda_oe    = sda_q;
    assign done      = done_q;
    assign rd_data   = sh_q;
    assign ack_level = ack_q;
endmodule

// File: rtl/twp_master_chk.sv
`timescale 1ns/1ps
module twp_master_chk
    import twp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       scl_oe,
    input logic       sda_oe
);
    logic [2:0] last_op;
    logic [3:0] rise_cnt;
    logic       scl_prev;
    logic       acc;

    assign acc = cmd_valid && !busy && op_known(cmd_op);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_op  <= 3'd0;
            rise_cnt <= '0;
            scl_prev <= 1'b0;
        end else begin
            scl_prev <= scl_oe;
            if (acc) begin
                last_op  <= cmd_op;
                rise_cnt <= '0;
            end else if (scl_prev && !scl_oe && rise_cnt != 4'd15) begin
                rise_cnt <= rise_cnt + 4'd1;
            end
        end
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r10_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));
    a_r11_bad_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !op_known(cmd_op)) |=> !busy);
    a_r3_start_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last_op == 3'd2) |-> (!scl_oe && sda_oe));
    a_r4_stop_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last_op == 3'd3) |-> (!scl_oe && !sda_oe));
    a_r9_recover_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last_op == 3'd1) |-> (!scl_oe && !sda_oe));
    a_r9_sda_free: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_op == 3'd1 && rise_cnt < 4'd9) |-> !sda_oe);
    a_r5_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_op == 3'd4 && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)));
endmodule

bind twp_master twp_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/sim_twp_master.sv
`timescale 1ns/1ps
module sim_twp_master;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic [7:0] tick_div;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [7:0] cmd_wdata;
    logic       cmd_ack;
    logic       sda_in, scl_oe, sda_oe, busy, done, ack_level;
    logic [7:0] rd_data;

    logic slv_pull, scl_line, sda_line;
    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slv_pull);
    assign sda_in   = sda_line;

    int         rises, starts, stops, mode, rd_idx;
    logic       ackwin, ack_plan;
    logic [8:0] cap;
    logic [7:0] rbyte;
    int         n_vec = 0, n_bad = 0;
    bit         finished = 0;

    twp_master u0 (
        .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
        .rd_data(rd_data), .ack_level(ack_level)
    );

    // Bus monitor and behavioural device
    always @(posedge scl_line) begin
        rises = rises + 1;
        cap   = {cap[7:0], sda_line};
    end
    always @(negedge scl_line) begin
        rd_idx = rises;
        ackwin = (rises == 8);
    end
    always @(negedge sda_line) if (scl_line === 1'b1) starts = starts + 1;
    always @(posedge sda_line) if (scl_line === 1'b1) stops  = stops + 1;
    always @(*) begin
        slv_pull = 1'b0;
        if (mode == 1 && ack_plan && ackwin) slv_pull = 1'b1;
        if (mode == 2 && rd_idx < 8 && !rbyte[7 - rd_idx]) slv_pull = 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [7:0] wd, input logic ak,
                       input logic [2:0] alt_op, input int hold, output int cyc);
        logic saw_busy;
        @(negedge clk);
        rises = 0; rd_idx = 0; ackwin = 1'b0; cap = '0;
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_ack = ak;
        @(negedge clk);
        saw_busy  = busy;
        cmd_op    = alt_op;
        cmd_valid = (hold > 0);
        cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            cmd_valid = (cyc < hold);
            if (done) break;
            if (cyc > 20000) begin
                chk("R10 done never seen", 0, 1);
                break;
            end
        end
        cmd_valid = 1'b0;
        chk("R10 busy after accept", saw_busy, 1);
        chk("R10 busy low at done", busy, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        int c, s0, s1, divs [4], quiet;
        pats[0] = 8'hA5; pats[1] = 8'h00; pats[2] = 8'hFF; pats[3] = 8'h3C;
        divs[0] = 1; divs[1] = 2; divs[2] = 3; divs[3] = 5;
        rises = 0; starts = 0; stops = 0; mode = 0; rd_idx = 8; ackwin = 1'b0;
        ack_plan = 1'b0; rbyte = 8'hFF; cap = '0;
        rst_n = 1'b0; tick_div = 8'd1; cmd_valid = 1'b0; cmd_op = 3'd0;
        cmd_wdata = 8'h00; cmd_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset lines", {30'd0, scl_oe, sda_oe}, 0);
        chk("R1 reset busy/done", {30'd0, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {29'd0, busy, scl_oe, sda_oe}, 0);

        foreach (divs[d]) begin
            tick_div = 8'(divs[d]);
            // START
            mode = 0; s0 = starts;
            run(3'd2, 8'h00, 1'b0, 3'd0, 0, c);
            chk("R2 start length", c, 3 * divs[d]);
            chk("R3 one start condition", starts - s0, 1);
            chk("R3 start end lines", {scl_oe, sda_oe}, 2'b01);
            // WRITE
            for (int k = 0; k < 4; k++) begin
                logic [7:0] b;
                b = pats[k] ^ 8'(divs[d]);
                mode = 1; ack_plan = (k % 2 == 0);
                run(3'd4, b, 1'b0, 3'd0, 0, c);
                chk("R2 write length", c, 37 * divs[d]);
                chk("R5 write bits msb first", cap[8:1], b);
                chk("R5 write nine clocks", rises, 9);
                chk("R6 ack level returned", ack_level, !ack_plan);
                chk("R6 ninth clock line", cap[0], !ack_plan);
            end
            // READ (SCL already low after the writes)
            for (int k = 0; k < 4; k++) begin
                logic ak;
                ak = k[0];
                rbyte = pats[k] ^ {4'(divs[d]), 4'h0};
                mode = 2;
                run(3'd5, 8'h00, ak, 3'd0, 0, c);
                chk("R2 read length", c, 29 * divs[d]);
                chk("R7 read byte", rd_data, rbyte);
                chk("R7 read nine clocks", rises, 9);
                chk("R8 sent ack on line", cap[0], ak);
                chk("R8 ack level returned", ack_level, ak);
                chk("R8 ack drive held", sda_oe, !ak);
            end
            // STOP
            mode = 0; s1 = stops;
            run(3'd3, 8'h00, 1'b0, 3'd0, 0, c);
            chk("R2 stop length", c, 4 * divs[d]);
            chk("R4 one stop condition", stops - s1, 1);
            chk("R4 stop end lines", {scl_oe, sda_oe}, 2'b00);
            // Command offered while busy
            run(3'd2, 8'h00, 1'b0, 3'd0, 0, c);
            mode = 1; ack_plan = 1'b1; s1 = stops;
            run(3'd4, 8'h96, 1'b0, 3'd3, 6, c);
            chk("R11 busy offer leaves write length", c, 37 * divs[d]);
            chk("R11 busy offer leaves data", cap[8:1], 8'h96);
            quiet = 0;
            repeat (60) begin
                @(negedge clk);
                if (done || busy) quiet++;
            end
            chk("R11 no late command", quiet, 0);
            chk("R11 no stop from ignored command", stops - s1, 0);
            chk("R11 lines unchanged", {scl_oe, sda_oe}, 2'b10);
            mode = 0;
            run(3'd3, 8'h00, 1'b0, 3'd0, 0, c);
            // Unknown op codes
            @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd6;
            @(negedge clk); cmd_op = 3'd7;
            @(negedge clk); cmd_op = 3'd0;
            @(negedge clk); cmd_valid = 1'b0;
            quiet = 0;
            repeat (20) begin
                @(negedge clk);
                if (done || busy) quiet++;
            end
            chk("R11 unknown op ignored", quiet, 0);
            chk("R11 unknown op lines", {scl_oe, sda_oe}, 2'b00);
            // RECOVER
            s0 = starts; s1 = stops;
            run(3'd1, 8'h00, 1'b0, 3'd0, 0, c);
            chk("R2 recover length", c, 40 * divs[d]);
            chk("R9 recover rising edges", rises, 10);
            chk("R9 SDA released over pulses", cap, 9'h1FE);
            chk("R9 trailing stop", stops - s1, 1);
            chk("R9 no start", starts - s0, 0);
            chk("R9 end lines", {scl_oe, sda_oe}, 2'b00);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule